// File: doc/BRIEF.md
# FIFO-fed pulse-width modulator

This block is a single-channel pulse-width modulator behind a small word-wide register port. Software queues duty values into a sample FIFO and sets a period and a prescaler. A counter steps once per prescaled tick and wraps every period. The output is active from each wrap until the counter reaches the current compare value. At a wrap the block takes a fresh compare value from the FIFO. It can also reuse each queued value for 1, 2, 4 or 8 periods, so the queue drains more slowly.

Status flags report FIFO occupancy, FIFO empty, a rejected FIFO write, rollover events and compare events. The output can run normal, inverted or forced off, and it is always low while the block is disabled. A control bit starts a self-clearing software reset. That reset empties the FIFO, restarts the counter and clears the control fields. Reads return data one clock after the request.

Top module: `fifo_pwm`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (status), 0x0C (sample) and 0x10 (period). A read request is answered on `bus_rdata` after the next clock edge. Any other offset reads as 0. The period register reads back the raw value written.
- R2: One output period lasts (P + 2) prescaled ticks, where P is the period register value. When every bit of P is 1, the period equals the one obtained with P = all-ones minus 1.
- R3: Control bits 15:4 hold the prescaler value D. One tick lasts D + 1 clocks, so D = 0 gives one tick per clock.
- R4: In normal mode the output is high for S ticks, starting at each rollover, where S is the active compare value. It is low for the rest of the period.
- R5: Control bits 19:18 select the output mode: 0 is normal, 1 is the complement of normal, and 2 holds the output low while the block runs.
- R6: While control bit 0 (enable) is 0, the output is 0 in every mode and the counter is held at its start.
- R7: Writing control bit 3 as 1 clears all other control fields and the status event flags, and starts a software reset. The reset empties the FIFO and restarts the counter. Bit 3 reads as 1 for SWR_CYCLES clocks and then as 0.
- R8: Control bits 2:1 set how many periods each sample is reused: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R9: The sample FIFO holds FIFO_DEPTH words. Status bits 2:0 give the number of queued words. Status bit 3 is 1 when the FIFO is empty.
- R10: A sample write to a full FIFO is discarded and sets status bit 6. Writing 1 to any of status bits 6:4 clears the corresponding flag.
- R11: Status bit 4 is set at each rollover. Status bit 5 is set on a tick where the counter equals the compare value.
- R12: A sample-register read returns the active compare value while enabled, and 0 while disabled.
- R13: At a rollover, the next queued sample becomes the compare value when two conditions hold: the current value has been used for its full repeat count, and the FIFO is not empty. Otherwise the compare value is kept. After reset the compare value is 0, so the first period after enabling is inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset of the accessed register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid one clock after the read strobe |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with an 8-bit counter, a 4-word FIFO and a 3-clock software reset. The narrow counter makes the all-ones period clamp cost only a few hundred clocks per period instead of tens of thousands. That puts clamp equivalence, prescaled periods and eight-fold repetition within one short run. The FIFO depth stays at 4, so the 4-word occupancy limit and the rejected fifth write are exercised at the field widths the status layout expects.

// File: rtl/fifo_pwm_pkg.sv
package fifo_pwm_pkg;

   localparam int OFF_CTL = 'h00;
   localparam int OFF_STA = 'h04;
   localparam int OFF_SMP = 'h0C;
   localparam int OFF_PER = 'h10;

   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_REP_LSB  = 1;
   localparam int CTL_SWR_BIT  = 3;
   localparam int CTL_DIV_LSB  = 4;
   localparam int CTL_MODE_LSB = 18;

   localparam int STA_EMPTY_BIT = 3;
   localparam int STA_ROV_BIT   = 4;
   localparam int STA_CMP_BIT   = 5;
   localparam int STA_FWE_BIT   = 6;

   typedef enum logic [1:0] {
      OUT_NORMAL = 2'd0,
      OUT_INVERT = 2'd1,
      OUT_OFF    = 2'd2,
      OUT_RSVD   = 2'd3
   } out_mode_e;

endpackage

// File: rtl/fifo_pwm_fifo.sv
module fifo_pwm_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int FCW   = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clear,
   input  logic           push,
   input  logic [W-1:0]   din,
   input  logic           pop,
   output logic [W-1:0]   dout,
   output logic [FCW-1:0] count,
   output logic           full,
   output logic           empty
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;

   generate
      if ((1 << PTR_W) == DEPTH) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         count <= count + FCW'(push) - FCW'(pop);
      end
   end

   assign dout  = mem[rd_ptr];
   assign full  = (count == FCW'(DEPTH));
   assign empty = (count == '0);

endmodule

// File: rtl/fifo_pwm_core.sv
module fifo_pwm_core #(
   parameter int CNT_W = 16,
   parameter int PRE_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             en,
   input  logic [PRE_W-1:0] div,
   input  logic [CNT_W-1:0] period,
   input  logic [1:0]       rep,
   input  logic             smp_avail,
   input  logic [CNT_W-1:0] smp_data,
   output logic             smp_pop,
   output logic [CNT_W-1:0] cmp_val,
   output logic             active,
   output logic             roll_evt,
   output logic             cmp_evt
);

   localparam logic [CNT_W-1:0] PER_MAX    = {{(CNT_W-1){1'b1}}, 1'b0};
   localparam logic [3:0]       USES_SPENT = 4'd8;

   logic [PRE_W-1:0] pre_cnt;
   logic [CNT_W-1:0] cnt, per_eff, cnt_top;
   logic [3:0]       uses, uses_inc, reps;
   logic             tick;

   assign per_eff  = (period > PER_MAX) ? PER_MAX : period;
   assign cnt_top  = per_eff + 1'b1;
   assign tick     = en && (pre_cnt == div);
   assign roll_evt = tick && (cnt == cnt_top);
   assign cmp_evt  = tick && (cnt == cmp_val);
   assign reps     = 4'd1 << rep;
   assign uses_inc = (uses == USES_SPENT) ? USES_SPENT : uses + 4'd1;
   assign smp_pop  = roll_evt && (uses_inc >= reps) && smp_avail;
   assign active   = (cnt < cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt <= '0;
         cnt     <= '0;
         cmp_val <= '0;
         uses    <= USES_SPENT;
      end else if (clear) begin
         pre_cnt <= '0;
         cnt     <= '0;
         cmp_val <= '0;
         uses    <= USES_SPENT;
      end else begin
         if (!en) begin
            pre_cnt <= '0;
            cnt     <= '0;
         end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
            if (tick) cnt <= roll_evt ? '0 : cnt + 1'b1;
         end
         if (roll_evt) begin
            if (smp_pop) begin
               cmp_val <= smp_data;
               uses    <= '0;
            end else begin
               uses <= uses_inc;
            end
         end
      end
   end

endmodule

// File: rtl/fifo_pwm.sv
module fifo_pwm
   import fifo_pwm_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int PRE_W      = 12,
   parameter int FIFO_DEPTH = 4,
   parameter int SWR_CYCLES = 4,
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);

   localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);
   localparam int SWR_W  = $clog2(SWR_CYCLES + 1);

   if (CNT_W < 4 || CNT_W > 16) begin : g_bad_cnt
      $error("CNT_W must lie in 4..16");
   end
   if (PRE_W < 1 || PRE_W > 12) begin : g_bad_pre
      $error("PRE_W must lie in 1..12");
   end
   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 7) begin : g_bad_depth
      $error("FIFO_DEPTH must lie in 2..7");
   end
   if (SWR_CYCLES < 1) begin : g_bad_swr
      $error("SWR_CYCLES must be at least 1");
   end
   if (DATA_W != 32 || ADDR_W < 5) begin : g_bad_bus
      $error("bus must be 32 bits wide with at least 5 address bits");
   end

   logic             ctl_en;
   logic [1:0]       ctl_rep;
   logic [PRE_W-1:0] ctl_div;
   out_mode_e        ctl_mode;
   logic [SWR_W-1:0] swr_cnt;
   logic [CNT_W-1:0] per_q;
   logic             fl_fwe, fl_cmp, fl_rov;

   logic              wr_ctl, wr_sta, wr_smp, wr_per;
   logic              swr_busy, swr_start;
   logic              fifo_full, fifo_empty, smp_push, smp_wr_err, smp_pop;
   logic [FCNT_W-1:0] fifo_count;
   logic [CNT_W-1:0]  fifo_head, cmp_val;
   logic              core_active, roll_evt, cmp_evt, mode_out;
   logic [DATA_W-1:0] rd_mux;
   logic              unused_wdata;

   assign wr_ctl     = bus_wr && (bus_addr == ADDR_W'(OFF_CTL));
   assign wr_sta     = bus_wr && (bus_addr == ADDR_W'(OFF_STA));
   assign wr_smp     = bus_wr && (bus_addr == ADDR_W'(OFF_SMP));
   assign wr_per     = bus_wr && (bus_addr == ADDR_W'(OFF_PER));
   assign swr_busy   = (swr_cnt != '0);
   assign swr_start  = wr_ctl && bus_wdata[CTL_SWR_BIT] && !swr_busy;
   assign smp_push   = wr_smp && !swr_busy && !fifo_full;
   assign smp_wr_err = wr_smp && !swr_busy && fifo_full;
   assign unused_wdata = &{1'b0, bus_wdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en   <= 1'b0;
         ctl_rep  <= '0;
         ctl_div  <= '0;
         ctl_mode <= OUT_NORMAL;
         swr_cnt  <= '0;
         per_q    <= '0;
         fl_fwe   <= 1'b0;
         fl_cmp   <= 1'b0;
         fl_rov   <= 1'b0;
      end else begin
         if (swr_busy) begin
            swr_cnt <= swr_cnt - 1'b1;
         end else if (swr_start) begin
            swr_cnt  <= SWR_W'(SWR_CYCLES);
            ctl_en   <= 1'b0;
            ctl_rep  <= '0;
            ctl_div  <= '0;
            ctl_mode <= OUT_NORMAL;
         end else if (wr_ctl) begin
            ctl_en   <= bus_wdata[CTL_EN_BIT];
            ctl_rep  <= bus_wdata[CTL_REP_LSB +: 2];
            ctl_div  <= bus_wdata[CTL_DIV_LSB +: PRE_W];
            ctl_mode <= out_mode_e'(bus_wdata[CTL_MODE_LSB +: 2]);
         end
         if (wr_per) per_q <= bus_wdata[CNT_W-1:0];
         if (swr_busy || swr_start) begin
            fl_fwe <= 1'b0;
            fl_cmp <= 1'b0;
            fl_rov <= 1'b0;
         end else begin
            fl_fwe <= smp_wr_err | (fl_fwe & ~(wr_sta & bus_wdata[STA_FWE_BIT]));
            fl_cmp <= cmp_evt    | (fl_cmp & ~(wr_sta & bus_wdata[STA_CMP_BIT]));
            fl_rov <= roll_evt   | (fl_rov & ~(wr_sta & bus_wdata[STA_ROV_BIT]));
         end
      end
   end

   fifo_pwm_fifo #(.W(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (swr_busy),
      .push  (smp_push),
      .din   (bus_wdata[CNT_W-1:0]),
      .pop   (smp_pop),
      .dout  (fifo_head),
      .count (fifo_count),
      .full  (fifo_full),
      .empty (fifo_empty)
   );

   fifo_pwm_core #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (swr_busy),
      .en        (ctl_en),
      .div       (ctl_div),
      .period    (per_q),
      .rep       (ctl_rep),
      .smp_avail (!fifo_empty),
      .smp_data  (fifo_head),
      .smp_pop   (smp_pop),
      .cmp_val   (cmp_val),
      .active    (core_active),
      .roll_evt  (roll_evt),
      .cmp_evt   (cmp_evt)
   );

   always_comb begin
      case (ctl_mode)
         OUT_NORMAL: mode_out = core_active;
         OUT_INVERT: mode_out = !core_active;
         default:    mode_out = 1'b0;
      endcase
   end
   assign pwm_out = ctl_en && mode_out;

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(OFF_CTL)) begin
         rd_mux[CTL_EN_BIT]            = ctl_en;
         rd_mux[CTL_REP_LSB +: 2]      = ctl_rep;
         rd_mux[CTL_SWR_BIT]           = swr_busy;
         rd_mux[CTL_DIV_LSB +: PRE_W]  = ctl_div;
         rd_mux[CTL_MODE_LSB +: 2]     = ctl_mode;
      end else if (bus_addr == ADDR_W'(OFF_STA)) begin
         rd_mux[FCNT_W-1:0]   = fifo_count;
         rd_mux[STA_EMPTY_BIT] = fifo_empty;
         rd_mux[STA_ROV_BIT]   = fl_rov;
         rd_mux[STA_CMP_BIT]   = fl_cmp;
         rd_mux[STA_FWE_BIT]   = fl_fwe;
      end else if (bus_addr == ADDR_W'(OFF_SMP)) begin
         rd_mux[CNT_W-1:0] = ctl_en ? cmp_val : '0;
      end else if (bus_addr == ADDR_W'(OFF_PER)) begin
         rd_mux[CNT_W-1:0] = per_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

endmodule

// File: rtl/fifo_pwm_chk.sv
module fifo_pwm_chk #(
   parameter int FIFO_DEPTH = 4,
   localparam int FCW = $clog2(FIFO_DEPTH + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           pwm_out,
   input logic           ctl_en,
   input logic           swr_busy,
   input logic [FCW-1:0] fifo_count,
   input logic           smp_wr_err,
   input logic           fl_fwe,
   input logic           smp_pop,
   input logic           roll_evt
);

   // R9
   fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_count <= FCW'(FIFO_DEPTH));

   // R6
   out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_en |-> !pwm_out);

   // R13
   pop_at_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_pop |-> roll_evt);

   // R10
   wr_err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_wr_err |=> fl_fwe);

   // R7
   swr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swr_busy |=> (fifo_count == '0));

   // R7
   swr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      swr_busy |-> !ctl_en);

   // R11
   roll_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      roll_evt |-> ctl_en);

endmodule

bind fifo_pwm fifo_pwm_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwm_out    (pwm_out),
   .ctl_en     (ctl_en),
   .swr_busy   (swr_busy),
   .fifo_count (fifo_count),
   .smp_wr_err (smp_wr_err),
   .fl_fwe     (fl_fwe),
   .smp_pop    (smp_pop),
   .roll_evt   (roll_evt)
);

// File: tb/fifo_pwm_bench.sv
`timescale 1ns/1ps
module fifo_pwm_bench;

   localparam int CW   = 8;
   localparam int DEP  = 4;
   localparam int SWRC = 3;
   localparam logic [4:0] A_CTL = 5'h00, A_STA = 5'h04, A_SMP = 5'h0C, A_PER = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   wire  [31:0] bus_rdata;
   wire         pwm_out;

   always #2.5 clk = ~clk;

   fifo_pwm #(.CNT_W(CW), .FIFO_DEPTH(DEP), .SWR_CYCLES(SWRC)) u_fifo_pwm (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pwm_out(pwm_out)
   );

   int checks = 0;
   int errors = 0;

   typedef struct { int hi; int per; } item_t;
   item_t exp_q[$];
   string cur_req = "R4";
   bit    mon_on = 1'b0;
   bit    mon_inv = 1'b0;
   bit    m_prev, m_started;
   int    m_hi, m_per;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bw(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic br(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: measures each active pulse plus period, compares with queue
   always @(negedge clk) begin
      logic a;
      item_t e;
      if (!mon_on) begin
         m_prev = 1'b0; m_started = 1'b0; m_hi = 0; m_per = 0;
      end else begin
         a = pwm_out ^ mon_inv;
         if (a && !m_prev) begin
            if (m_started && exp_q.size() > 0) begin
               e = exp_q.pop_front();
               check({cur_req, " active"}, m_hi, e.hi);
               check({cur_req, " period"}, m_per, e.per);
            end
            m_started = 1'b1; m_hi = 0; m_per = 0;
         end
         if (m_started) begin
            m_per++;
            if (a) m_hi++;
         end
         m_prev = a;
      end
   end

   task automatic soft_reset();
      bw(A_CTL, 32'h8);
      idle(SWRC + 3);
   endtask

   task automatic expect_run(input int s, input int times, input int div, input int eff);
      item_t it;
      for (int j = 0; j < times; j++) begin
         it.hi  = s * (div + 1);
         it.per = (eff + 2) * (div + 1);
         exp_q.push_back(it);
      end
   endtask

   task automatic go_and_drain(input logic [31:0] ctl, input bit inv);
      mon_inv = inv;
      bw(A_CTL, ctl);
      mon_on = 1'b1;
      while (exp_q.size() != 0) @(posedge clk);
      mon_on = 1'b0;
      bw(A_CTL, 32'h0);
   endtask

   task automatic run_case(input string req, input int div, input int per_reg, input int eff,
                           input int rep, input int mode, input int s0, input int s1);
      soft_reset();
      bw(A_PER, per_reg);
      bw(A_SMP, s0);
      bw(A_SMP, s1);
      cur_req = req;
      expect_run(s0, 1 << rep, div, eff);
      expect_run(s1, 1 << rep, div, eff);
      expect_run(s1, 1, div, eff);   // held after FIFO drains (R13)
      go_and_drain(32'h1 | (rep << 1) | (div << 4) | (mode << 18), mode == 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      bit hit;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // reset state
      br(A_CTL, d); check("R1 reset control", d, 32'h0);
      br(A_STA, d); check("R9 reset status", d, 32'h08);
      check("R6 reset output", pwm_out, 1'b0);
      br(5'h08, d); check("R1 unmapped offset", d, 32'h0);

      // control fields read back, then cleared by software reset
      bw(A_CTL, (32'd5 << 4) | (32'd3 << 1) | (32'd1 << 18));
      br(A_CTL, d); check("R1 control readback", d, (32'd5 << 4) | (32'd3 << 1) | (32'd1 << 18));
      hit = 1'b0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out) hit = 1'b1; end
      check("R6 disabled inverted output", hit, 1'b0);
      bw(A_SMP, 9); bw(A_SMP, 9);
      br(A_STA, d); check("R9 two words queued", d, 32'h02);
      bw(A_CTL, 32'h8);
      br(A_CTL, d); check("R7 reset bit busy", d, 32'h8);
      idle(SWRC + 3);
      br(A_CTL, d); check("R7 reset bit self-clears", d, 32'h0);
      br(A_STA, d); check("R7 FIFO flushed", d, 32'h08);

      // R4 R10 R13: full FIFO, dropped fifth write, normal waveform
      bw(A_PER, 10);
      bw(A_SMP, 3); bw(A_SMP, 7); bw(A_SMP, 1); bw(A_SMP, 11);
      br(A_STA, d); check("R9 four words queued", d, 32'h04);
      bw(A_SMP, 5);
      br(A_STA, d); check("R10 write error on full", d, 32'h44);
      bw(A_STA, 32'h70);
      br(A_STA, d); check("R10 write-one clears error", d, 32'h04);
      br(A_SMP, d); check("R12 disabled sample read", d, 32'h0);
      cur_req = "R4";
      expect_run(3, 1, 0, 10);
      expect_run(7, 1, 0, 10);
      expect_run(1, 1, 0, 10);
      expect_run(11, 1, 0, 10);
      expect_run(11, 1, 0, 10);   // R13: dropped 5 must not appear, 11 held
      go_and_drain(32'h1, 1'b0);

      // R3 prescaler: ratio 3
      run_case("R3", 2, 5, 5, 0, 0, 2, 4);
      // R8 repeat four times
      run_case("R8", 0, 6, 6, 2, 0, 1, 5);
      // R8 repeat eight times with prescaler
      run_case("R8 x8", 1, 4, 4, 3, 0, 3, 2);
      // R5 inverted mode
      run_case("R5", 0, 8, 8, 0, 1, 2, 6);

      // R2 clamp: all-ones period equals all-ones minus one
      soft_reset();
      bw(A_PER, 32'hFF);
      br(A_PER, d); check("R1 period raw readback", d, 32'hFF);
      run_case("R2 all-ones", 0, 'hFF, 'hFE, 0, 0, 100, 40);
      run_case("R2 max", 0, 'hFE, 'hFE, 0, 0, 100, 40);

      // R5 forced off, R11 flags, R12 readback
      soft_reset();
      bw(A_PER, 4);
      bw(A_SMP, 2);
      bw(A_CTL, 32'h1 | (32'd2 << 18));
      hit = 1'b0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (pwm_out) hit = 1'b1; end
      check("R5 forced-off output", hit, 1'b0);
      br(A_SMP, d); check("R12 enabled sample read", d, 32'h2);
      br(A_STA, d); check("R11 rollover and compare flags", d & 32'h70, 32'h30);
      bw(A_CTL, 32'h0);
      br(A_SMP, d); check("R12 sample read after disable", d, 32'h0);
      bw(A_STA, 32'h70);
      br(A_STA, d); check("R11 flags cleared, FIFO empty", d, 32'h08);
      idle(8);
      br(A_STA, d); check("R6 no events while disabled", d, 32'h08);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule